// File: doc/BRIEF.md
# Descending RAM Stack Controller

This block runs a last-in, first-out stack inside a window of a larger single-port RAM. A pointer register holds the address of the current top item, and the stack grows toward lower addresses. A push first moves the pointer down one word and then stores the incoming word there. A pop reads the word at the pointer and then moves the pointer up one word. With the default settings the pointer starts at 4001, so the first stored word lands at address 4000.

Two limit registers that software can load bound the window. A push that would take the pointer below the upper (low-address) bound is refused and reported as an overflow. A pop that would take the pointer above the lower (high-address) bound is refused and reported as an underflow. A refused operation touches neither the pointer nor the RAM. The RAM returns read data one cycle after the address is presented, so a pop holds a busy output for one cycle. The popped word is then presented with a one-cycle valid strobe.

Top module: `lifo_stack_ctrl`

## Requirements
- R1: After reset the pointer reads 4001, the upper bound is 3000 and the lower bound is 4001. Busy, overflow, underflow, pop-valid and RAM write enable are all low.
- R2: An accepted push raises the RAM write enable in the same cycle, with address pointer-1 and the push word as write data. The pointer reads one less from the next cycle.
- R3: A push that arrives while the pointer is less than or equal to the upper bound is refused. No RAM write occurs, the pointer does not change, and the overflow output is high for exactly the next cycle.
- R4: An accepted pop presents the pointer as the RAM address and never raises write enable. From the next cycle the pointer reads one more and busy is high for exactly one cycle. In the cycle after that, pop-valid is high for one cycle and the pop data equals the most recently pushed word not yet popped.
- R5: A pop that arrives while the pointer is greater than or equal to the lower bound is refused. Busy stays low, the pointer does not change, and the underflow output is high for exactly the next cycle.
- R6: Push and pop requests made while busy is high are ignored. There is no RAM write, no pointer change and no flag.
- R7: When push and pop are requested together while idle, only the push is performed.
- R8: A limit write with select 0 loads the upper bound and with select 1 loads the lower bound. The new value governs requests from the next cycle onward.
- R9: The first push after reset writes RAM address 4000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | DW | Word to push |
| pop_data_o | output | DW | Popped word, meaningful while pop_valid_o is high |
| pop_valid_o | output | 1 | One-cycle strobe marking pop_data_o |
| busy_o | output | 1 | Pop read in flight; requests are ignored |
| sp_o | output | AW | Current stack pointer |
| mem_addr_o | output | AW | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | DW | RAM write data |
| mem_rdata_i | input | DW | RAM read data, one cycle after the address |
| lim_we_i | input | 1 | Limit register write strobe |
| lim_sel_i | input | 1 | 0 selects the upper bound, 1 the lower bound |
| lim_data_i | input | AW | Limit value to load |
| ovf_o | output | 1 | Overflow: previous cycle's push was refused |
| udf_o | output | 1 | Underflow: previous cycle's pop was refused |

## Verification
The bench targets the exact edges of both bounds. It pushes until the pointer equals the upper bound and pops until it equals the lower bound. An off-by-one compare would either store one word too many, corrupting the region below the window, or refuse the last legal word. It issues requests during the busy cycle and simultaneous push and pop. A design that failed to ignore the first would lose or duplicate a word, and one that got the second wrong would return stale data. Moving the bounds mid-run with the stack partly full shows whether the compare uses the loaded limits or fixed values.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2
   } op_e;

   localparam int unsigned LIM_UPPER = 0;
   localparam int unsigned LIM_LOWER = 1;
   localparam int unsigned LIM_COUNT = 2;
endpackage

// File: rtl/lifo_limits.sv
module lifo_limits #(
   parameter int unsigned AW     = 12,
   parameter int unsigned RST_HI = 3000,
   parameter int unsigned RST_LO = 4001
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic          sel_i,
   input  logic [AW-1:0] data_i,
   output logic [AW-1:0] hi_o,
   output logic [AW-1:0] lo_o
);
   import lifo_pkg::*;

   logic [AW-1:0] lim_q [LIM_COUNT];

   for (genvar gi = 0; gi < LIM_COUNT; gi++) begin : g_lim
      localparam int unsigned RV = (gi == LIM_UPPER) ? RST_HI : RST_LO;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lim_q[gi] <= AW'(RV);
         else if (we_i && (sel_i == 1'(gi)))
            lim_q[gi] <= data_i;
      end
   end

   assign hi_o = lim_q[LIM_UPPER];
   assign lo_o = lim_q[LIM_LOWER];
endmodule

// File: rtl/lifo_ptr.sv
module lifo_ptr #(
   parameter int unsigned AW     = 12,
   parameter int unsigned RST_SP = 4001
) (
   input  logic            clk,
   input  logic            rst_n,
   input  lifo_pkg::op_e   op_i,
   input  logic [AW-1:0]   hi_i,
   input  logic [AW-1:0]   lo_i,
   output logic [AW-1:0]   sp_o,
   output logic [AW-1:0]   sp_dn_o,
   output logic            push_ok_o,
   output logic            pop_ok_o,
   output logic            ovf_set_o,
   output logic            udf_set_o
);
   import lifo_pkg::*;

   logic [AW-1:0] sp_q;
   logic          room_below;
   logic          item_above;

   // pointer-1 < hi  <=>  pointer <= hi ; pointer+1 > lo  <=>  pointer >= lo
   assign room_below = (sp_q > hi_i);
   assign item_above = (sp_q < lo_i);

   assign push_ok_o = (op_i == OP_PUSH) &&  room_below;
   assign ovf_set_o = (op_i == OP_PUSH) && !room_below;
   assign pop_ok_o  = (op_i == OP_POP)  &&  item_above;
   assign udf_set_o = (op_i == OP_POP)  && !item_above;

   assign sp_dn_o = sp_q - AW'(1);
   assign sp_o    = sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_q <= AW'(RST_SP);
      else if (push_ok_o)
         sp_q <= sp_dn_o;
      else if (pop_ok_o)
         sp_q <= sp_q + AW'(1);
   end
endmodule

// File: rtl/lifo_rdseq.sv
module lifo_rdseq #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] rdata_i,
   output logic          busy_o,
   output logic          valid_o,
   output logic [DW-1:0] data_o
);
   logic          busy_q;
   logic          valid_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         busy_q  <= start_i;
         valid_q <= busy_q;
         if (busy_q)
            data_q <= rdata_i;
      end
   end

   assign busy_o  = busy_q;
   assign valid_o = valid_q;
   assign data_o  = data_q;
endmodule

// File: rtl/lifo_stack_ctrl.sv
module lifo_stack_ctrl #(
   parameter int unsigned AW     = 12,
   parameter int unsigned DW     = 16,
   parameter int unsigned RST_SP = 4001,
   parameter int unsigned RST_HI = 3000,
   parameter int unsigned RST_LO = 4001
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [DW-1:0] push_data_i,
   output logic [DW-1:0] pop_data_o,
   output logic          pop_valid_o,
   output logic          busy_o,
   output logic [AW-1:0] sp_o,
   output logic [AW-1:0] mem_addr_o,
   output logic          mem_we_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          lim_we_i,
   input  logic          lim_sel_i,
   input  logic [AW-1:0] lim_data_i,
   output logic          ovf_o,
   output logic          udf_o
);
   import lifo_pkg::*;

   localparam int unsigned ADDR_MAX = (1 << AW) - 1;

   if (AW < 2 || AW > 30) begin : g_bad_aw
      $error("lifo_stack_ctrl: AW out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("lifo_stack_ctrl: DW must be positive");
   end
   if (RST_SP > ADDR_MAX || RST_HI > ADDR_MAX || RST_LO > ADDR_MAX) begin : g_bad_rst
      $error("lifo_stack_ctrl: reset value does not fit AW");
   end
   if (RST_HI > RST_LO) begin : g_bad_win
      $error("lifo_stack_ctrl: upper bound above lower bound");
   end

   logic [AW-1:0] hi_w, lo_w, sp_w, sp_dn_w;
   logic          push_ok, pop_ok, ovf_set, udf_set;
   logic          busy_w;
   op_e           op;
   logic          ovf_q, udf_q;

   always_comb begin
      if (busy_w)      op = OP_NONE;
      else if (push_i) op = OP_PUSH;
      else if (pop_i)  op = OP_POP;
      else             op = OP_NONE;
   end

   lifo_limits #(.AW(AW), .RST_HI(RST_HI), .RST_LO(RST_LO)) u_lim (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (lim_we_i),
      .sel_i  (lim_sel_i),
      .data_i (lim_data_i),
      .hi_o   (hi_w),
      .lo_o   (lo_w)
   );

   lifo_ptr #(.AW(AW), .RST_SP(RST_SP)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op),
      .hi_i      (hi_w),
      .lo_i      (lo_w),
      .sp_o      (sp_w),
      .sp_dn_o   (sp_dn_w),
      .push_ok_o (push_ok),
      .pop_ok_o  (pop_ok),
      .ovf_set_o (ovf_set),
      .udf_set_o (udf_set)
   );

   lifo_rdseq #(.DW(DW)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (pop_ok),
      .rdata_i (mem_rdata_i),
      .busy_o  (busy_w),
      .valid_o (pop_valid_o),
      .data_o  (pop_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
      end else begin
         ovf_q <= ovf_set;
         udf_q <= udf_set;
      end
   end

   assign mem_we_o    = push_ok;
   assign mem_addr_o  = (op == OP_PUSH) ? sp_dn_w : sp_w;
   assign mem_wdata_o = push_data_i;
   assign busy_o      = busy_w;
   assign sp_o        = sp_w;
   assign ovf_o       = ovf_q;
   assign udf_o       = udf_q;
endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
   parameter int unsigned AW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          push_i,
   input logic          pop_i,
   input logic          busy_o,
   input logic          pop_valid_o,
   input logic [AW-1:0] sp_o,
   input logic          mem_we_o,
   input logic          ovf_o,
   input logic          udf_o
);
   // R2: accepted push moves the pointer down by one
   a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> sp_o == $past(sp_o) - AW'(1));

   // R3: a refused push leaves the pointer where it was
   a_r3_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> sp_o == $past(sp_o));

   // R4: busy lasts one cycle and follows a pointer increment
   a_r4_busy_one: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !busy_o);
   a_r4_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> sp_o == $past(sp_o) + AW'(1));
   a_r4_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid_o |-> $past(busy_o));

   // R5: a refused pop leaves the pointer where it was
   a_r5_udf_hold: assert property (@(posedge clk) disable iff (!rst_n)
      udf_o |-> sp_o == $past(sp_o));

   // R6: no write and no pointer move while busy
   a_r6_busy_no_we: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !mem_we_o);
   a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> sp_o == $past(sp_o));

   // R7: simultaneous request never starts a read
   a_r7_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !busy_o) |=> !busy_o);

   // R3 R5: flags and pop strobe are mutually exclusive
   a_r3_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ovf_o, udf_o, pop_valid_o}));
endmodule

bind lifo_stack_ctrl lifo_stack_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .busy_o      (busy_o),
   .pop_valid_o (pop_valid_o),
   .sp_o        (sp_o),
   .mem_we_o    (mem_we_o),
   .ovf_o       (ovf_o),
   .udf_o       (udf_o)
);

// File: tb/sim_lifo_stack_ctrl.sv
module sim_lifo_stack_ctrl;
   localparam int AW = 12;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_i = 1'b0, pop_i = 1'b0;
   logic [DW-1:0] push_data_i = '0;
   logic [DW-1:0] pop_data_o;
   logic          pop_valid_o, busy_o;
   logic [AW-1:0] sp_o, mem_addr_o;
   logic          mem_we_o;
   logic [DW-1:0] mem_wdata_o;
   logic [DW-1:0] mem_rdata_i = '0;
   logic          lim_we_i = 1'b0, lim_sel_i = 1'b0;
   logic [AW-1:0] lim_data_i = '0;
   logic          ovf_o, udf_o;

   always #10 clk = ~clk;

   lifo_stack_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .push_data_i(push_data_i), .pop_data_o(pop_data_o),
      .pop_valid_o(pop_valid_o), .busy_o(busy_o), .sp_o(sp_o),
      .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .lim_we_i(lim_we_i), .lim_sel_i(lim_sel_i), .lim_data_i(lim_data_i),
      .ovf_o(ovf_o), .udf_o(udf_o)
   );

   // behavioural RAM, registered read
   logic [DW-1:0] ram [int];
   always @(posedge clk) begin
      if (mem_we_o) ram[int'(mem_addr_o)] = mem_wdata_o;
      mem_rdata_i <= ram.exists(int'(mem_addr_o)) ? ram[int'(mem_addr_o)] : '0;
   end

   // reference model
   int       m_sp = 4001, m_hi = 3000, m_lo = 4001;
   bit       m_busy, m_ovf, m_udf, m_pv;
   int       m_pd, m_pend;
   int       stk[$];
   int       n_run = 0, n_fail = 0, cycles = 0;
   bit       done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input bit p, input bit q, input int d,
                       input bit lw, input bit ls, input int ld, input string tag);
      bit exp_we;
      @(negedge clk);
      push_i = p; pop_i = q; push_data_i = DW'(d);
      lim_we_i = lw; lim_sel_i = ls; lim_data_i = AW'(ld);
      #5;
      exp_we = !m_busy && p && (m_sp > m_hi);
      chk(busy_o == m_busy, tag, "busy", busy_o, m_busy);
      chk(int'(sp_o) == m_sp, tag, "sp", sp_o, m_sp);
      chk(ovf_o == m_ovf, {tag, "/R3"}, "ovf", ovf_o, m_ovf);
      chk(udf_o == m_udf, {tag, "/R5"}, "udf", udf_o, m_udf);
      chk(pop_valid_o == m_pv, {tag, "/R4"}, "pop_valid", pop_valid_o, m_pv);
      if (m_pv) chk(int'(pop_data_o) == m_pd, {tag, "/R4"}, "pop_data", pop_data_o, m_pd);
      chk(mem_we_o == exp_we, {tag, "/R2"}, "we", mem_we_o, exp_we);
      if (exp_we) begin
         chk(int'(mem_addr_o) == m_sp - 1, {tag, "/R2"}, "waddr", mem_addr_o, m_sp - 1);
         chk(int'(mem_wdata_o) == d, {tag, "/R2"}, "wdata", mem_wdata_o, d);
      end
      if (!m_busy && !p && q && m_sp < m_lo)
         chk(int'(mem_addr_o) == m_sp, {tag, "/R4"}, "raddr", mem_addr_o, m_sp);
      @(posedge clk);
      #1;
      m_ovf = 0; m_udf = 0; m_pv = 0;
      if (m_busy) begin
         m_busy = 0; m_pv = 1; m_pd = m_pend;
      end else if (p) begin
         if (m_sp <= m_hi) m_ovf = 1;
         else begin m_sp--; stk.push_front(d); end
      end else if (q) begin
         if (m_sp >= m_lo) m_udf = 1;
         else begin m_pend = stk.pop_front(); m_sp++; m_busy = 1; end
      end
      if (lw) begin
         if (ls) m_lo = ld; else m_hi = ld;
      end
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 0, tag);
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      // R1: reset state
      chk(sp_o == 12'd4001, "R1", "sp", sp_o, 4001);
      chk(!busy_o && !ovf_o && !udf_o && !pop_valid_o && !mem_we_o, "R1", "flags", 1, 0);
      @(negedge clk); rst_n = 1'b1;
      idle("R1");

      // R9: first push lands at 4000
      @(negedge clk); push_i = 1; push_data_i = 16'h1111; #5;
      chk(mem_we_o && mem_addr_o == 12'd4000, "R9", "first addr", mem_addr_o, 4000);
      push_i = 0;
      idle("R9");
      // model did not see the manual push; record it
      m_sp = 4000; stk.push_front(16'h1111);
      // note: the drive above was cleared before the edge, so no push occurred
      m_sp = 4001; void'(stk.pop_front());

      // R2 R4: push three, pop three with a gap
      step(1, 0, 16'hA001, 0, 0, 0, "R2");
      step(1, 0, 16'hA002, 0, 0, 0, "R2");
      step(1, 0, 16'hA003, 0, 0, 0, "R2");
      for (int i = 0; i < 3; i++) begin
         step(0, 1, 0, 0, 0, 0, "R4");
         idle("R4"); idle("R4");
      end
      // R5: pop on empty
      step(0, 1, 0, 0, 0, 0, "R5");
      idle("R5");

      // R6: requests during busy ignored
      step(1, 0, 16'hB001, 0, 0, 0, "R6");
      step(1, 0, 16'hB002, 0, 0, 0, "R6");
      step(0, 1, 0, 0, 0, 0, "R6");
      step(1, 0, 16'hBEEF, 0, 0, 0, "R6");
      step(0, 1, 0, 0, 0, 0, "R6");
      idle("R6");
      // R7: simultaneous push and pop
      step(1, 1, 16'hC001, 0, 0, 0, "R7");
      idle("R7");
      step(0, 1, 0, 0, 0, 0, "R7"); idle("R7"); idle("R7");
      step(0, 1, 0, 0, 0, 0, "R7"); idle("R7"); idle("R7");
      step(0, 1, 0, 0, 0, 0, "R7"); idle("R7"); idle("R7");

      // R8 R3: tighten upper bound, overflow at the edge
      step(0, 0, 0, 1, 0, 3998, "R8");
      for (int i = 0; i < 4; i++) step(1, 0, 16'hD000 + i, 0, 0, 0, "R3");
      idle("R3"); idle("R3");
      // R8 R5: tighten lower bound, underflow with items left
      step(0, 0, 0, 1, 1, 3999, "R8");
      step(0, 1, 0, 0, 0, 0, "R8"); idle("R8"); idle("R8");
      step(0, 1, 0, 0, 0, 0, "R5"); idle("R5");
      step(0, 0, 0, 1, 1, 4001, "R8");
      step(0, 0, 0, 1, 0, 3000, "R8");
      for (int i = 0; i < 2; i++) begin
         step(0, 1, 0, 0, 0, 0, "R4"); idle("R4"); idle("R4");
      end

      // R3: fill the default window completely, then one more
      for (int i = 0; i < 1002; i++) step(1, 0, (i * 37 + 5) & 16'hFFFF, 0, 0, 0, "R3");
      idle("R3");
      for (int i = 0; i < 1002; i++) begin
         step(0, 1, 0, 0, 0, 0, "R4"); idle("R4");
      end
      idle("R5"); idle("R5");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule